// File: doc/BRIEF.md
# Dual-Mode Bus Request Arbiter

This block decides which of five requesters owns a shared parallel bus. One requester is the built-in host. The other four are external masters, and each has its own request input and grant output. Grants come from a register. They are one-hot, or all zero when nobody owns the bus. Once an owner holds the bus, it keeps it for as long as the bus is busy and its request stays high.

A single mode input selects how a new owner is chosen. With the mode low, the choice follows a fixed ranking in which the host is always strongest. With the mode high, the choice follows a stored five-entry ranking. Each time the bus passes to a different requester, that new owner is taken out of the ranking, the entries below it move up one place, and it goes in at the bottom. The stored ranking starts out equal to the fixed ranking. It is kept unchanged while the fixed mode is in use.

Top module: `prio_bus_arbiter`

## Requirements
- R1: At most one grant output is high in any cycle. A grant is only high in a cycle that follows a cycle in which that requester's request input was high.
- R2: While `bus_idle` is low and the current owner keeps its request high, the grant outputs do not change, whatever the other requests or the mode input do.
- R3: An arbitration decision is taken in every cycle in which `bus_idle` is high, no grant is held, or the owner's request is low. Its result appears on the grant outputs one clock later.
- R4: With `rr_mode` at 0, a decision grants the highest-ranked active requester in the order host, external 0, external 1, external 2, external 3. The host therefore wins every decision it takes part in.
- R5: With `rr_mode` at 1, a decision grants the highest-ranked active requester in the stored ranking. When that requester is not the current owner, it moves to the bottom of the ranking and the entries below its old place move up one position.
- R6: During and straight after reset all grants are low, and the stored ranking equals the fixed order of R4.
- R7: A decision taken with no request active clears all grants and leaves the stored ranking unchanged.
- R8: A change of `rr_mode` applies from the next decision on. Decisions taken in fixed mode never alter the stored ranking, so a later return to `rr_mode` at 1 resumes the ranking as it was left.
- R9: A decision that grants the requester already holding the bus leaves the stored ranking unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 0: fixed ranking, 1: last new owner drops to the bottom |
| bus_idle | input | 1 | High when no transfer is in progress; allows re-arbitration |
| host_req | input | 1 | Request from the built-in host |
| ext_req | input | NUM_EXT | Requests from the external masters, bit k for master k |
| host_gnt | output | 1 | Grant to the built-in host |
| ext_gnt | output | NUM_EXT | Grants to the external masters, bit k for master k |

## Verification
The assertions assume that every input is a synchronous level, sampled only at the rising edge, and that `bus_idle` may rise or fall in any cycle without regard to the grants. They make no assumption about requesters keeping their requests high until granted, because a request may be withdrawn at any time. The bench therefore changes all inputs only at the falling edge. It mixes directed sequences with random requests whose owner tends to keep requesting, and it pulses `bus_idle` at random. This produces long held grants as well as frequent re-arbitration, in both modes and across mode changes.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Kind of change a decision makes to bus ownership
  typedef enum logic [1:0] {
    EV_HOLD    = 2'd0,
    EV_KEEP    = 2'd1,
    EV_NEW     = 2'd2,
    EV_RELEASE = 2'd3
  } arb_event_e;

  localparam int HOST_SLOT = 0;

endpackage

// File: rtl/arb_order_list.sv
module arb_order_list #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rr_move,
  input  logic [IW-1:0] win_idx,
  output logic [N*IW-1:0] order_flat
);

  logic [N*IW-1:0] order_q;
  logic [N*IW-1:0] order_d;

  function automatic logic [IW-1:0] slot_of(input logic [N*IW-1:0] ord, input int pos);
    return ord[pos*IW +: IW];
  endfunction

  // Take the winner out, close the gap, put the winner last
  function automatic logic [N*IW-1:0] demote(input logic [N*IW-1:0] ord,
                                              input logic [IW-1:0] who);
    logic [N*IW-1:0] res;
    logic            passed;
    res    = ord;
    passed = 1'b0;
    for (int i = 0; i < N - 1; i++) begin
      if (slot_of(ord, i) == who) passed = 1'b1;
      if (passed) res[i*IW +: IW] = slot_of(ord, i + 1);
    end
    res[(N-1)*IW +: IW] = who;
    return res;
  endfunction

  function automatic logic [N*IW-1:0] natural_order();
    logic [N*IW-1:0] res;
    for (int i = 0; i < N; i++) res[i*IW +: IW] = IW'(i);
    return res;
  endfunction

  assign order_d = rr_move ? demote(order_q, win_idx) : order_q;

  always_ff @(posedge clk) begin
    if (!rst_n) order_q <= natural_order();
    else        order_q <= order_d;
  end

  assign order_flat = order_q;

endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]    req,
  input  logic [N*IW-1:0] order_flat,
  input  logic            rr_mode,
  output logic            found,
  output logic [IW-1:0]   win_idx
);

  logic [N*IW-1:0] active_order;

  function automatic logic req_at(input logic [N-1:0] r, input logic [IW-1:0] idx);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < N; k++) if (idx == IW'(k)) hit = r[k];
    return hit;
  endfunction

  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      assign active_order[g*IW +: IW] = rr_mode ? order_flat[g*IW +: IW] : IW'(g);
    end
  endgenerate

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && req_at(req, active_order[i*IW +: IW])) begin
        found   = 1'b1;
        win_idx = active_order[i*IW +: IW];
      end
    end
  end

endmodule

// File: rtl/arb_owner.sv
module arb_owner
  import arb_pkg::*;
#(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          bus_idle,
  input  logic          rr_mode,
  input  logic          found,
  input  logic [IW-1:0] win_idx,
  output logic [N-1:0]  gnt,
  output logic          decide,
  output logic          rr_move,
  output arb_event_e    ev
);

  logic [N-1:0] gnt_q;
  logic [N-1:0] gnt_d;
  logic [N-1:0] win_vec;
  logic         owner_live;
  logic         same_owner;

  function automatic logic [N-1:0] one_hot(input logic [IW-1:0] idx);
    logic [N-1:0] v;
    v = '0;
    for (int k = 0; k < N; k++) if (idx == IW'(k)) v[k] = 1'b1;
    return v;
  endfunction

  assign owner_live = |(gnt_q & req);
  assign decide     = bus_idle || !owner_live;
  assign win_vec    = found ? one_hot(win_idx) : '0;
  assign same_owner = |(win_vec & gnt_q);

  always_comb begin
    if (!decide)      ev = EV_HOLD;
    else if (!found)  ev = EV_RELEASE;
    else if (same_owner) ev = EV_KEEP;
    else              ev = EV_NEW;
  end

  assign rr_move = rr_mode && (ev == EV_NEW);
  assign gnt_d   = decide ? win_vec : gnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rr_mode,
  input  logic               bus_idle,
  input  logic               host_req,
  input  logic [NUM_EXT-1:0] ext_req,
  output logic               host_gnt,
  output logic [NUM_EXT-1:0] ext_gnt
);

  localparam int N  = NUM_EXT + 1;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]    req_all;
  logic [N-1:0]    gnt_all;
  logic [N*IW-1:0] order_flat;
  logic            found;
  logic [IW-1:0]   win_idx;
  logic            decide;
  logic            rr_move;
  arb_event_e      ev;

  assign req_all = {ext_req, host_req};

  arb_order_list #(.N(N), .IW(IW)) u_order (
    .clk        (clk),
    .rst_n      (rst_n),
    .rr_move    (rr_move),
    .win_idx    (win_idx),
    .order_flat (order_flat)
  );

  arb_select #(.N(N), .IW(IW)) u_select (
    .req        (req_all),
    .order_flat (order_flat),
    .rr_mode    (rr_mode),
    .found      (found),
    .win_idx    (win_idx)
  );

  arb_owner #(.N(N), .IW(IW)) u_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_all),
    .bus_idle (bus_idle),
    .rr_mode  (rr_mode),
    .found    (found),
    .win_idx  (win_idx),
    .gnt      (gnt_all),
    .decide   (decide),
    .rr_move  (rr_move),
    .ev       (ev)
  );

  assign host_gnt = gnt_all[HOST_SLOT];
  assign ext_gnt  = gnt_all[N-1:1];

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rr_mode,
  input logic            bus_idle,
  input logic [N-1:0]    req_all,
  input logic [N-1:0]    gnt_all,
  input logic [N*IW-1:0] order_flat,
  input logic            decide,
  input logic            found,
  input logic            rr_move,
  input logic [IW-1:0]   win_idx
);

  logic [N-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < N; i++)
      for (int k = 0; k < N; k++)
        if (order_flat[i*IW +: IW] == IW'(k)) present[k] = 1'b1;
  end

  // R1
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_all));

  // R1
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_all) |-> ((gnt_all & $past(req_all)) != '0));

  // R2
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle && ((gnt_all & req_all) != '0)) |=> $stable(gnt_all));

  // R3
  grant_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && found) |=> ($countones(gnt_all) == 1));

  // R4
  host_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !rr_mode && req_all[0]) |=> gnt_all[0]);

  // R5
  winner_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_move |=> (order_flat[(N-1)*IW +: IW] == $past(win_idx)));

  // R5
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == N);

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && (req_all == '0)) |=> (gnt_all == '0));

  // R8
  fixed_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_mode |-> !rr_move);

  // R9
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_move |=> $stable(order_flat));

endmodule

bind prio_bus_arbiter arb_checker #(.N(N), .IW(IW)) u_arb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rr_mode    (rr_mode),
  .bus_idle   (bus_idle),
  .req_all    (req_all),
  .gnt_all    (gnt_all),
  .order_flat (order_flat),
  .decide     (decide),
  .found      (found),
  .rr_move    (rr_move),
  .win_idx    (win_idx)
);

// File: tb/test_prio_bus_arbiter.sv
module test_prio_bus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NR = NE + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rr_mode = 1'b0;
  logic          bus_idle = 1'b0;
  logic          host_req = 1'b0;
  logic [NE-1:0] ext_req = '0;
  logic          host_gnt;
  logic [NE-1:0] ext_gnt;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  int    rank_q[$];
  int    owner = -1;
  string last_tag = "R6";

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_bus_arbiter #(.NUM_EXT(NE)) i_prio_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .bus_idle(bus_idle),
    .host_req(host_req), .ext_req(ext_req),
    .host_gnt(host_gnt), .ext_gnt(ext_gnt)
  );

  function automatic logic [NR-1:0] expect_vec();
    logic [NR-1:0] v = '0;
    if (owner >= 0) v[owner] = 1'b1;
    return v;
  endfunction

  task automatic compare(string tag);
    logic [NR-1:0] act;
    logic [NR-1:0] exp_v;
    act   = {ext_gnt, host_gnt};
    exp_v = expect_vec();
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: grants actual %b expected %b at %0t", tag, act, exp_v, $time);
    end
    n_cmp++;
    if ($countones(act) > 1) begin
      n_bad++;
      $display("FAIL R1: grants actual %b expected at most one bit", act);
    end
  endtask

  task automatic model_reset();
    rank_q.delete();
    for (int i = 0; i < NR; i++) rank_q.push_back(i);
    owner = -1;
  endtask

  task automatic model_step(logic [NR-1:0] r, bit mode, bit idle);
    int view[$];
    int win;
    bit dec;
    dec = idle || (owner < 0) || !r[owner];
    if (!dec) return;
    if (mode) view = rank_q;
    else for (int i = 0; i < NR; i++) view.push_back(i);
    win = -1;
    foreach (view[i]) if (win < 0 && r[view[i]]) win = view[i];
    if (win >= 0 && mode && win != owner) begin
      for (int i = 0; i < rank_q.size(); i++)
        if (rank_q[i] == win) begin rank_q.delete(i); break; end
      rank_q.push_back(win);
    end
    owner = win;
  endtask

  // one cycle: check last result, apply new inputs, advance model
  task automatic cyc(bit h, logic [NE-1:0] e, bit mode, bit idle, string tag);
    @(negedge clk);
    compare(last_tag);
    host_req = h; ext_req = e; rr_mode = mode; bus_idle = idle;
    model_step({e, h}, mode, idle);
    last_tag = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NE-1:0] e;
    bit h;
    model_reset();
    // R6: grants low while reset held, even with all requests up
    host_req = 1'b1; ext_req = '1; bus_idle = 1'b1;
    repeat (3) begin
      @(negedge clk);
      compare("R6");
    end
    rst_n = 1'b1;
    host_req = 1'b0; ext_req = '0;
    last_tag = "R6";

    // R4: fixed ranking, host beats all
    cyc(1, 4'b1111, 0, 1, "R4");
    cyc(0, 4'b1111, 0, 1, "R4");
    cyc(0, 4'b1100, 0, 1, "R4");
    cyc(0, 4'b1000, 0, 1, "R4");
    // R2: owner external 3 holds while busy, host requests
    cyc(1, 4'b1000, 0, 0, "R2");
    cyc(1, 4'b1000, 1, 0, "R2");
    // R3: owner drops, host gets bus though bus busy
    cyc(1, 4'b0000, 0, 0, "R3");
    cyc(0, 4'b0110, 0, 0, "R3");
    // R7: nothing requested
    cyc(0, 4'b0000, 0, 1, "R7");
    cyc(0, 4'b0000, 1, 1, "R7");

    // R6/R5: rr starts from fixed ranking, host first then demoted
    cyc(1, 4'b1111, 1, 1, "R5");
    cyc(1, 4'b1111, 1, 1, "R5");
    cyc(1, 4'b1111, 1, 1, "R5");
    cyc(1, 4'b1111, 1, 1, "R5");
    cyc(1, 4'b1111, 1, 1, "R5");
    cyc(1, 4'b1111, 1, 1, "R5");
    // R9: same owner re-granted, ranking untouched
    cyc(0, 4'b0010, 1, 1, "R9");
    cyc(0, 4'b0010, 1, 1, "R9");
    cyc(1, 4'b0011, 1, 1, "R9");
    // R8: fixed mode, then resume rr with stored ranking
    cyc(1, 4'b1111, 0, 1, "R8");
    cyc(0, 4'b1111, 0, 1, "R8");
    cyc(1, 4'b1111, 1, 1, "R8");
    cyc(1, 4'b1111, 1, 1, "R8");
    cyc(0, 4'b0000, 1, 1, "R7");

    // random phases in both modes (R1, R3, R5)
    for (int ph = 0; ph < 6; ph++) begin
      for (int n = 0; n < 1500; n++) begin
        e = 4'($urandom);
        h = 1'($urandom);
        if (owner >= 0 && ($urandom % 4) != 0) begin
          if (owner == 0) h = 1'b1; else e[owner-1] = 1'b1;
        end
        cyc(h, e, ph[0], ($urandom % 10) < 3, ph[0] ? "R5" : "R3");
      end
    end
    cyc(0, 4'b0000, 0, 1, "R7");
    @(negedge clk);
    compare(last_tag);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule